// File: doc/BRIEF.md
# Interrupt acknowledge cycle responder

This block lets a peripheral raise interrupts on an asynchronous, strobe-based host bus and answer the host's interrupt acknowledge cycles. It has three request lines. Each line is open-drain: the block either pulls it low or leaves it released. Each request has a programmable 7-bit level register and an 8-bit vector register. Both are loaded through a synchronous configuration write port.

When the host runs an acknowledge cycle, the block compares the low address bits with the three level registers. It then does one of two things:
- If a pending request matches, it places that request's vector on the data bus and asserts the transfer acknowledge. It holds the acknowledge until the host lifts the data strobe.
- If no pending request matches, it passes the acknowledge to the next device in a daisy chain.

When several pending requests match the same address, the lowest-numbered request wins. The host-side bus inputs are brought into the clock domain through two-flop synchronisers before the block uses them.

Top module: `irq_ack_responder`

## Requirements
- R1: Each bit of `irq_drive_low` equals the corresponding bit of `irq_pending` delayed by one clock. The block has no port that drives a request line high.
- R2: An acknowledge cycle is recognised only while `iackin_n`=0, `ds_n`=0 and `cs_n`=1 (after synchronisation). Otherwise `dtack_n` and `iackout_n` stay 1.
- R3: A configuration write is `cfg_we`=1 at a clock edge. The register is selected by `cfg_addr`:
  - `cfg_addr[0]`=0 loads the level register from `cfg_wdata[6:0]`.
  - `cfg_addr[0]`=1 loads the vector register from `cfg_wdata[7:0]`.
  - `cfg_addr[2:1]` gives the request index 0..2.
  - Reset clears every level and vector register to 0.
- R4: In a recognised cycle, a request matches when it is pending and its level equals `addr`. If any request matches, then within 4 clocks `dtack_n`=0, `data_oe`=1 and `data_out` carries the winner's vector.
- R5: `dtack_n` stays 0 for as long as `ds_n` stays 0. Within 4 clocks of `ds_n` rising, `dtack_n` returns to 1 and `data_oe` to 0.
- R6: When several requests match, the lowest-numbered one is acknowledged. This holds even when all level registers hold identical values.
- R7: If no request matches, `iackout_n`=0 within 4 clocks while `dtack_n` stays 1 and `data_oe` stays 0. `iackout_n` returns to 1 within 4 clocks of `iackin_n` rising.
- R8: After reset, `dtack_n`=1, `iackout_n`=1, `data_oe`=0, `data_out`=0 and `irq_drive_low`=0.
- R9: Only one acknowledge is given while `iackin_n` stays low. A second `ds_n` strobe before `iackin_n` rises gets no `dtack_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pending | input | 3 | Pending request flags, one per request |
| irq_drive_low | output | 3 | 1 = pull that request line low; 0 = release it |
| iackin_n | input | 1 | Acknowledge-in from the daisy chain, active low |
| ds_n | input | 1 | Host data strobe, active low |
| cs_n | input | 1 | Chip select, active low |
| addr | input | 7 | Low host address bits |
| data_out | output | 8 | Vector byte driven during an acknowledge |
| data_oe | output | 1 | Data bus output enable |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| iackout_n | output | 1 | Acknowledge-out to the next device, active low |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | {request index, vector/level select} |
| cfg_wdata | input | 8 | Configuration write data |

## Verification
Random stimulus draws the levels from a small range of values. This makes ties and misses frequent, so each cycle separates an acknowledged winner from a forwarded cycle, and separates the correct winner from a wrong one. Directed cases cover the remaining behaviour:
- identical levels on all three requests with everything pending, which exposes the tie-break order;
- a cycle with chip select asserted, which must be ignored;
- a long-held strobe, which must keep `dtack_n` asserted;
- a second strobe within one acknowledge-in, which must get no response.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_PASS = 2'd2,
    ST_WAIT = 2'd3
  } ack_state_t;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= INIT;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ack_cfg_regs.sv
module ack_cfg_regs #(
  parameter int NREQ  = 3,
  parameter int LVL_W = 7,
  parameter int VEC_W = 8,
  localparam int IW   = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [IW:0]                 waddr,
  input  logic [VEC_W-1:0]            wdata,
  output logic [NREQ-1:0][LVL_W-1:0]  level,
  output logic [NREQ-1:0][VEC_W-1:0]  vector
);
  for (genvar g = 0; g < NREQ; g++) begin : g_req
    logic sel;
    assign sel = we && (waddr[IW:1] == IW'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        level[g]  <= '0;
        vector[g] <= '0;
      end else if (sel) begin
        if (waddr[0]) vector[g] <= wdata;
        else          level[g]  <= wdata[LVL_W-1:0];
      end
    end
  end
endmodule

// File: rtl/ack_arbiter.sv
module ack_arbiter #(
  parameter int NREQ  = 3,
  parameter int LVL_W = 7,
  localparam int IW   = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NREQ-1:0]             pending,
  input  logic [NREQ-1:0][LVL_W-1:0]  level,
  input  logic [LVL_W-1:0]            addr,
  output logic                        hit,
  output logic [IW-1:0]               win_idx,
  output logic [NREQ-1:0]             grant
);
  logic [NREQ-1:0] match;

  for (genvar g = 0; g < NREQ; g++) begin : g_cmp
    assign match[g] = pending[g] && (level[g] == addr);
  end

  always_comb begin
    grant   = '0;
    win_idx = '0;
    for (int i = NREQ-1; i >= 0; i--) begin
      if (match[i]) begin
        grant   = '0;
        grant[i] = 1'b1;
        win_idx = IW'(i);
      end
    end
  end

  assign hit = |match;

  // R6: one winner at most, and it is the lowest matching index
  a_r6_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && (hit == (grant != '0)));
  a_r6_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    (hit && match[0]) |-> grant[0]);
endmodule

// File: rtl/irq_ack_responder.sv
module irq_ack_responder
  import irq_ack_pkg::*;
#(
  parameter int NREQ        = 3,
  parameter int LVL_W       = 7,
  parameter int VEC_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IW         = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NREQ-1:0]   irq_pending,
  output logic [NREQ-1:0]   irq_drive_low,
  input  logic              iackin_n,
  input  logic              ds_n,
  input  logic              cs_n,
  input  logic [LVL_W-1:0]  addr,
  output logic [VEC_W-1:0]  data_out,
  output logic              data_oe,
  output logic              dtack_n,
  output logic              iackout_n,
  input  logic              cfg_we,
  input  logic [IW:0]       cfg_addr,
  input  logic [VEC_W-1:0]  cfg_wdata
);
  localparam int SW = LVL_W + 3;

  logic [SW-1:0] bus_raw, bus_s;
  logic iack_s, ds_s, cs_s;
  logic [LVL_W-1:0] addr_s;

  assign bus_raw = {iackin_n, ds_n, cs_n, addr};

  bus_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES), .INIT({3'b111, {LVL_W{1'b0}}})) u_sync (
    .clk(clk), .rst(rst), .d(bus_raw), .q(bus_s)
  );
  assign {iack_s, ds_s, cs_s, addr_s} = bus_s;

  logic [NREQ-1:0][LVL_W-1:0] level;
  logic [NREQ-1:0][VEC_W-1:0] vector;

  ack_cfg_regs #(.NREQ(NREQ), .LVL_W(LVL_W), .VEC_W(VEC_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .level(level), .vector(vector)
  );

  logic            hit;
  logic [IW-1:0]   win_idx;
  logic [NREQ-1:0] grant;

  ack_arbiter #(.NREQ(NREQ), .LVL_W(LVL_W)) u_arb (
    .clk(clk), .rst(rst), .pending(irq_pending), .level(level), .addr(addr_s),
    .hit(hit), .win_idx(win_idx), .grant(grant)
  );

  logic cyc_valid;
  assign cyc_valid = !iack_s && !ds_s && cs_s;

  ack_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_drive_low <= '0;
    end else begin
      irq_drive_low <= irq_pending;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      dtack_n   <= 1'b1;
      iackout_n <= 1'b1;
      data_oe   <= 1'b0;
      data_out  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cyc_valid) begin
            if (hit) begin
              state    <= ST_ACK;
              dtack_n  <= 1'b0;
              data_oe  <= 1'b1;
              data_out <= vector[win_idx];
            end else begin
              state     <= ST_PASS;
              iackout_n <= 1'b0;
            end
          end
        end
        ST_ACK: begin
          if (ds_s) begin
            state    <= ST_WAIT;
            dtack_n  <= 1'b1;
            data_oe  <= 1'b0;
            data_out <= '0;
          end
        end
        ST_WAIT: begin
          if (iack_s) state <= ST_IDLE;
        end
        ST_PASS: begin
          if (iack_s) begin
            state     <= ST_IDLE;
            iackout_n <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: a response starts only from a recognised acknowledge cycle
  a_r2_valid_cycle: assert property (@(posedge clk) disable iff (rst)
    ($fell(dtack_n) || $fell(iackout_n)) |-> ($past(cs_s) && !$past(ds_s) && !$past(iack_s)));
  // R5: acknowledge held while the strobe stays low
  a_r5_dtack_hold: assert property (@(posedge clk) disable iff (rst)
    (!dtack_n && !ds_s) |=> !dtack_n);
  // R5: output enable only together with the acknowledge
  a_r5_oe_with_dtack: assert property (@(posedge clk) disable iff (rst)
    data_oe == !dtack_n);
  // R7: never answer and forward in the same cycle
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!dtack_n && !iackout_n));
  // R7: forwarding stops once acknowledge-in is released
  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    (!iackout_n && iack_s) |=> iackout_n);
  // R9: after release, no new acknowledge until acknowledge-in goes high
  a_r9_single: assert property (@(posedge clk) disable iff (rst)
    ($rose(dtack_n) && !iack_s) |=> dtack_n);
endmodule

// File: tb/sim_irq_ack_responder.sv
module sim_irq_ack_responder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] irq_pending = '0;
  logic [2:0] irq_drive_low;
  logic iackin_n = 1'b1, ds_n = 1'b1, cs_n = 1'b1;
  logic [6:0] addr = '0;
  logic [7:0] data_out;
  logic data_oe, dtack_n, iackout_n;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;

  int checks = 0;
  int errors = 0;
  logic [6:0] m_lvl [3];
  logic [7:0] m_vec [3];

  always #4 clk = ~clk;

  irq_ack_responder u0 (
    .clk(clk), .rst(rst), .irq_pending(irq_pending), .irq_drive_low(irq_drive_low),
    .iackin_n(iackin_n), .ds_n(ds_n), .cs_n(cs_n), .addr(addr),
    .data_out(data_out), .data_oe(data_oe), .dtack_n(dtack_n), .iackout_n(iackout_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input int idx, input bit is_vec, input logic [7:0] val);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = {2'(idx), is_vec};
    cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    if (is_vec) m_vec[idx] = val;
    else        m_lvl[idx] = val[6:0];
  endtask

  function automatic int exp_winner(input logic [2:0] pend, input logic [6:0] a);
    for (int i = 0; i < 3; i++)
      if (pend[i] && m_lvl[i] == a) return i;
    return -1;
  endfunction

  task automatic run_cycle(input logic [6:0] a, input string tag);
    int w;
    w = exp_winner(irq_pending, a);
    addr = a; cs_n = 1'b1; iackin_n = 1'b0;
    wait_clk(1);
    ds_n = 1'b0;
    wait_clk(5);
    if (w >= 0) begin
      check(dtack_n == 1'b0 && data_oe == 1'b1, {tag, " R4 dtack/oe"}, int'(dtack_n), 0);
      check(data_out == m_vec[w], {tag, " R4 R6 vector"}, int'(data_out), int'(m_vec[w]));
      check(iackout_n == 1'b1, {tag, " R7 no forward on hit"}, int'(iackout_n), 1);
      ds_n = 1'b1;
      wait_clk(5);
      check(dtack_n == 1'b1 && data_oe == 1'b0, {tag, " R5 release"}, int'(dtack_n), 1);
    end else begin
      check(iackout_n == 1'b0, {tag, " R7 forward"}, int'(iackout_n), 0);
      check(dtack_n == 1'b1 && data_oe == 1'b0, {tag, " R7 no dtack"}, int'(dtack_n), 1);
      ds_n = 1'b1;
    end
    iackin_n = 1'b1;
    wait_clk(5);
    check(iackout_n == 1'b1, {tag, " R7 iackout idle"}, int'(iackout_n), 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    for (int i = 0; i < 3; i++) begin m_lvl[i] = '0; m_vec[i] = '0; end
    wait_clk(3);
    rst = 1'b0;
    wait_clk(1);
    // R8
    check(dtack_n && iackout_n && !data_oe && data_out == 0 && irq_drive_low == 0,
          "R8 reset state", int'({dtack_n, iackout_n, data_oe}), 6);

    // R1
    irq_pending = 3'b101;
    wait_clk(2);
    check(irq_drive_low == 3'b101, "R1 drive low", int'(irq_drive_low), 5);
    irq_pending = 3'b010;
    wait_clk(2);
    check(irq_drive_low == 3'b010, "R1 drive low", int'(irq_drive_low), 2);

    // R3: program distinct levels and vectors
    cfg_write(0, 0, 8'h05); cfg_write(1, 0, 8'h06); cfg_write(2, 0, 8'h07);
    cfg_write(0, 1, 8'hA0); cfg_write(1, 1, 8'hB1); cfg_write(2, 1, 8'hC2);
    irq_pending = 3'b111;
    wait_clk(2);
    run_cycle(7'h06, "R3 distinct");
    run_cycle(7'h07, "R3 distinct");
    run_cycle(7'h09, "R3 miss");

    // R6: identical levels, all pending -> request 0
    cfg_write(0, 0, 8'h11); cfg_write(1, 0, 8'h11); cfg_write(2, 0, 8'h11);
    run_cycle(7'h11, "R6 tie all");
    irq_pending = 3'b110;
    wait_clk(2);
    run_cycle(7'h11, "R6 tie 1,2");

    // R2: chip select asserted -> not an acknowledge cycle
    cs_n = 1'b0; addr = 7'h11; iackin_n = 1'b0;
    wait_clk(1);
    ds_n = 1'b0;
    wait_clk(6);
    check(dtack_n == 1'b1 && iackout_n == 1'b1, "R2 cs active ignored",
          int'({dtack_n, iackout_n}), 3);
    ds_n = 1'b1; iackin_n = 1'b1; cs_n = 1'b1;
    wait_clk(5);

    // R5 long strobe, then R9 second strobe within one iackin
    addr = 7'h11; iackin_n = 1'b0;
    wait_clk(1);
    ds_n = 1'b0;
    wait_clk(30);
    check(dtack_n == 1'b0, "R5 held during long strobe", int'(dtack_n), 0);
    ds_n = 1'b1;
    wait_clk(5);
    check(dtack_n == 1'b1, "R5 released", int'(dtack_n), 1);
    ds_n = 1'b0;
    wait_clk(6);
    check(dtack_n == 1'b1 && data_oe == 1'b0, "R9 second strobe ignored", int'(dtack_n), 1);
    ds_n = 1'b1; iackin_n = 1'b1;
    wait_clk(5);

    // Random mix with small level range to force ties and misses
    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < 3; i++) begin
        cfg_write(i, 0, 8'($urandom_range(0, 3)));
        cfg_write(i, 1, 8'($urandom));
      end
      irq_pending = 3'($urandom);
      wait_clk(2);
      run_cycle(7'($urandom_range(0, 3)), "R4 R6 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule